// File: doc/BRIEF.md
# Serial bridge vendor request decoder

This block sits behind a USB device controller that has already parsed each control transfer. It receives the setup fields (request type, request code and data length), then the data stage one byte at a time. It maps each supported vendor request onto a shadow register that a serial engine consumes: the line control byte, the modem control byte, the baud divisor and a flag that gates transmission on CTS. Two read requests return either the live modem status byte or the stored line control byte. A write-direction request with its own code is acknowledged and changes nothing.

Each request is first checked against a fixed table of (type, code, length) triples. A request that fails the check raises a one-cycle stall pulse and changes no register. A divisor write collects its bytes least significant first. The whole divisor is replaced in one cycle, when the last byte arrives. A separate status report path captures the modem status and line status bytes on request. It then presents them on two consecutive cycles for the interrupt-in endpoint, modem status first.

Top module: `usbser_vreq_dec`

## Requirements
- R1: After reset: line control is 0x03, modem control is 0x00, the divisor is RESET_DIV (12), the CTS gate is 0, and rd_valid, req_stall, req_done, div_load and rpt_valid are all 0.
- R2: Type 0x40, code 7, length 1 writes the data byte to lcr_out. The new value and a one-cycle req_done pulse both appear in the cycle after the edge that takes the byte.
- R3: Type 0x40, code 10, length 1 writes mcr_out with bits 7:5 forced to zero and bits 4:0 taken from the byte.
- R4: Type 0x40, code 5, length 4 carries the divisor, least significant byte first. div_out keeps its old value until the fourth byte is taken. It then changes as a whole in the next cycle, and div_load pulses for exactly that cycle.
- R5: Type 0x40, code 12, length 1 sets cts_gate to 1 for a nonzero byte and to 0 for a zero byte. tx_allow is 1 when cts_gate is 0 or msr_in bit 4 (CTS) is 1.
- R6: Type 0x40, code 11, length 1 completes with req_done but leaves lcr_out, mcr_out, div_out and cts_gate unchanged.
- R7: Type 0xC0 with length 1 opens a read stage in the cycle after setup. With code 2, rd_data follows msr_in; with code 6, rd_data shows lcr_out. rd_valid holds until rd_take, and req_done pulses in the cycle after that.
- R8: A setup with an unknown code, a direction that does not match the code, or a length other than the code's size gives a req_stall pulse in the next cycle. It opens no data stage, so later wr_valid bytes are ignored, and no register changes.
- R9: A setup_valid during an open data stage abandons that request. A divisor write cut short this way leaves div_out unchanged.
- R10: A rpt_start while the report path is idle captures msr_in and lsr_in. rpt_valid is then 1 for the next two cycles, with rpt_data showing the captured modem status and then the captured line status. A rpt_start while a report is in progress is ignored.
- R11: wr_valid with no write stage open changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | One-cycle pulse carrying a new setup |
| setup_type | input | 8 | Request type byte |
| setup_code | input | 8 | Request code |
| setup_len | input | LEN_W | Data stage length in bytes |
| wr_valid | input | 1 | Host-to-device data byte present |
| wr_data | input | 8 | Host-to-device data byte |
| rd_take | input | 1 | Host consumes the read byte |
| rd_valid | output | 1 | Device-to-host byte available |
| rd_data | output | 8 | Device-to-host byte |
| req_done | output | 1 | Request completed (one-cycle pulse) |
| req_stall | output | 1 | Request rejected (one-cycle pulse) |
| msr_in | input | 8 | Live modem status from the serial engine, CTS at bit 4 |
| lsr_in | input | 8 | Live line status from the serial engine |
| rpt_start | input | 1 | Begin a two-byte status report |
| rpt_valid | output | 1 | Report byte present |
| rpt_data | output | 8 | Report byte |
| lcr_out | output | 8 | Line control shadow |
| mcr_out | output | 8 | Modem control shadow |
| div_out | output | 8*DIV_BYTES | Baud divisor |
| div_load | output | 1 | Divisor just replaced |
| cts_gate | output | 1 | Transmission waits for CTS |
| tx_allow | output | 1 | Transmitter may send |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the status report capture and a control request that reads or writes through the same path. The bench raises rpt_start in the same cycle as a setup that opens a modem status read. While the report bytes are still streaming, it changes msr_in and completes the read. The report must keep its captured bytes while rd_data follows the live status. The second pair is a new setup and a pending divisor byte. The bench presents a setup in the same cycle as a wr_valid byte, and the reference model requires the byte to be dropped and the old divisor to stay in place.

// File: rtl/usbser_vreq_pkg.sv
package usbser_vreq_pkg;

  localparam logic [7:0] RT_OUT = 8'h40;
  localparam logic [7:0] RT_IN  = 8'hC0;

  localparam logic [7:0] RQ_GET_MSR  = 8'd2;
  localparam logic [7:0] RQ_SET_DIV  = 8'd5;
  localparam logic [7:0] RQ_GET_LCR  = 8'd6;
  localparam logic [7:0] RQ_SET_LCR  = 8'd7;
  localparam logic [7:0] RQ_SET_MCR  = 8'd10;
  localparam logic [7:0] RQ_NOP      = 8'd11;
  localparam logic [7:0] RQ_SET_GATE = 8'd12;

  localparam int MSR_CTS_BIT = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_OUT, ST_IN} stage_t;

  // Expected data stage size for a (type, code) pair; zero marks it unsupported.
  function automatic logic [7:0] data_size(input logic [7:0] rtype,
                                           input logic [7:0] code,
                                           input int div_bytes);
    logic [7:0] sz;
    sz = 8'd0;
    if (rtype == RT_OUT) begin
      case (code)
        RQ_SET_DIV:                              sz = 8'(div_bytes);
        RQ_SET_LCR, RQ_SET_MCR, RQ_NOP, RQ_SET_GATE: sz = 8'd1;
        default:                                 sz = 8'd0;
      endcase
    end else if (rtype == RT_IN) begin
      case (code)
        RQ_GET_MSR, RQ_GET_LCR: sz = 8'd1;
        default:                sz = 8'd0;
      endcase
    end
    return sz;
  endfunction

  // Modem control keeps only its five low bits.
  function automatic logic [7:0] mcr_keep(input logic [7:0] v);
    return v & 8'h1F;
  endfunction

endpackage

// File: rtl/usbser_vreq_decode.sv
module usbser_vreq_decode
  import usbser_vreq_pkg::*;
#(
  parameter int DIV_BYTES = 4,
  parameter int LEN_W     = 16,
  localparam int CNT_W    = $clog2(DIV_BYTES + 1)
) (
  input  logic [7:0]       rtype,
  input  logic [7:0]       code,
  input  logic [LEN_W-1:0] len,
  output logic             legal,
  output logic             dir_in,
  output logic [CNT_W-1:0] last_idx
);
  logic [7:0] need;

  always_comb begin
    need     = data_size(rtype, code, DIV_BYTES);
    legal    = (need != 8'd0) && (len == LEN_W'(need));
    dir_in   = (rtype == RT_IN);
    last_idx = CNT_W'(need - 8'd1);
  end
endmodule

// File: rtl/usbser_vreq_ctrl.sv
module usbser_vreq_ctrl
  import usbser_vreq_pkg::*;
#(
  parameter int DIV_BYTES = 4,
  localparam int DIV_W    = 8 * DIV_BYTES,
  localparam int CNT_W    = $clog2(DIV_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic [7:0]       setup_code,
  input  logic             legal,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] last_idx,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             rd_take,
  output stage_t           stage,
  output logic [7:0]       cur_code,
  output logic             commit_fire,
  output logic [DIV_W-1:0] commit_word,
  output logic             req_done,
  output logic             req_stall
);
  stage_t           stage_q;
  logic [7:0]       code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_q;
  logic             byte_taken;
  logic             read_end;

  // A setup in the same cycle always wins over a pending data byte or read.
  assign byte_taken  = (stage_q == ST_OUT) && wr_valid && !setup_valid;
  assign commit_fire = byte_taken && (cnt_q == last_q);
  assign read_end    = (stage_q == ST_IN) && rd_take && !setup_valid;
  assign stage       = stage_q;
  assign cur_code    = code_q;

  for (genvar i = 0; i < DIV_BYTES; i++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q <= 8'd0;
      else if (byte_taken && (cnt_q == CNT_W'(i)))
        lane_q <= wr_data;
    end
    // The final byte goes straight into the committed word.
    assign commit_word[8*i +: 8] = (cnt_q == CNT_W'(i)) ? wr_data : lane_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q   <= ST_IDLE;
      code_q    <= 8'd0;
      cnt_q     <= '0;
      last_q    <= '0;
      req_done  <= 1'b0;
      req_stall <= 1'b0;
    end else begin
      req_done  <= commit_fire || read_end;
      req_stall <= setup_valid && !legal;
      if (setup_valid) begin
        code_q  <= setup_code;
        cnt_q   <= '0;
        last_q  <= last_idx;
        stage_q <= !legal ? ST_IDLE : (dir_in ? ST_IN : ST_OUT);
      end else if (commit_fire) begin
        stage_q <= ST_IDLE;
      end else if (byte_taken) begin
        cnt_q   <= cnt_q + CNT_W'(1);
      end else if (read_end) begin
        stage_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/usbser_vreq_regs.sv
module usbser_vreq_regs
  import usbser_vreq_pkg::*;
#(
  parameter int         DIV_BYTES = 4,
  parameter int         RESET_DIV = 12,
  parameter logic [7:0] RESET_LCR = 8'h03,
  localparam int        DIV_W     = 8 * DIV_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_fire,
  input  logic [7:0]       commit_code,
  input  logic [DIV_W-1:0] commit_word,
  output logic [7:0]       lcr_q,
  output logic [7:0]       mcr_q,
  output logic [DIV_W-1:0] div_q,
  output logic             div_load,
  output logic             gate_q
);
  logic [7:0] low_byte;
  assign low_byte = commit_word[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q    <= RESET_LCR;
      mcr_q    <= 8'd0;
      div_q    <= DIV_W'(RESET_DIV);
      div_load <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      div_load <= commit_fire && (commit_code == RQ_SET_DIV);
      if (commit_fire) begin
        case (commit_code)
          RQ_SET_LCR:  lcr_q  <= low_byte;
          RQ_SET_MCR:  mcr_q  <= mcr_keep(low_byte);
          RQ_SET_DIV:  div_q  <= commit_word;
          RQ_SET_GATE: gate_q <= (low_byte != 8'd0);
          default:     ;
        endcase
      end
    end
  end
endmodule

// File: rtl/usbser_vreq_report.sv
module usbser_vreq_report (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rpt_start,
  input  logic [7:0] msr_in,
  input  logic [7:0] lsr_in,
  output logic       rpt_valid,
  output logic       rpt_first,
  output logic [7:0] rpt_data
);
  logic [1:0] left_q;
  logic [7:0] msr_s;
  logic [7:0] lsr_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= 2'd0;
      msr_s  <= 8'd0;
      lsr_s  <= 8'd0;
    end else if (left_q == 2'd0) begin
      if (rpt_start) begin
        left_q <= 2'd2;
        msr_s  <= msr_in;
        lsr_s  <= lsr_in;
      end
    end else begin
      left_q <= left_q - 2'd1;
    end
  end

  assign rpt_valid = (left_q != 2'd0);
  assign rpt_first = (left_q == 2'd2);
  assign rpt_data  = rpt_first ? msr_s : lsr_s;
endmodule

// File: rtl/usbser_vreq_dec.sv
module usbser_vreq_dec
  import usbser_vreq_pkg::*;
#(
  parameter int         DIV_BYTES = 4,
  parameter int         LEN_W     = 16,
  parameter int         RESET_DIV = 12,
  parameter logic [7:0] RESET_LCR = 8'h03,
  localparam int        DIV_W     = 8 * DIV_BYTES,
  localparam int        CNT_W     = $clog2(DIV_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic [7:0]       setup_type,
  input  logic [7:0]       setup_code,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             rd_take,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             req_done,
  output logic             req_stall,
  input  logic [7:0]       msr_in,
  input  logic [7:0]       lsr_in,
  input  logic             rpt_start,
  output logic             rpt_valid,
  output logic [7:0]       rpt_data,
  output logic [7:0]       lcr_out,
  output logic [7:0]       mcr_out,
  output logic [DIV_W-1:0] div_out,
  output logic             div_load,
  output logic             cts_gate,
  output logic             tx_allow
);
  logic             legal;
  logic             dir_in;
  logic [CNT_W-1:0] last_idx;
  stage_t           stage;
  logic [7:0]       cur_code;
  logic             commit_fire;
  logic [DIV_W-1:0] commit_word;
  logic             rpt_first;

  usbser_vreq_decode #(.DIV_BYTES(DIV_BYTES), .LEN_W(LEN_W)) u_decode (
    .rtype(setup_type), .code(setup_code), .len(setup_len),
    .legal(legal), .dir_in(dir_in), .last_idx(last_idx)
  );

  usbser_vreq_ctrl #(.DIV_BYTES(DIV_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_code(setup_code),
    .legal(legal), .dir_in(dir_in), .last_idx(last_idx),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_take(rd_take),
    .stage(stage), .cur_code(cur_code), .commit_fire(commit_fire),
    .commit_word(commit_word), .req_done(req_done), .req_stall(req_stall)
  );

  usbser_vreq_regs #(.DIV_BYTES(DIV_BYTES), .RESET_DIV(RESET_DIV), .RESET_LCR(RESET_LCR)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_fire(commit_fire), .commit_code(cur_code),
    .commit_word(commit_word), .lcr_q(lcr_out), .mcr_q(mcr_out), .div_q(div_out),
    .div_load(div_load), .gate_q(cts_gate)
  );

  usbser_vreq_report u_report (
    .clk(clk), .rst_n(rst_n), .rpt_start(rpt_start), .msr_in(msr_in), .lsr_in(lsr_in),
    .rpt_valid(rpt_valid), .rpt_first(rpt_first), .rpt_data(rpt_data)
  );

  assign rd_valid = (stage == ST_IN);
  assign rd_data  = (cur_code == RQ_GET_MSR) ? msr_in : lcr_out;
  assign tx_allow = !cts_gate || msr_in[MSR_CTS_BIT];
endmodule

// File: rtl/usbser_vreq_chk.sv
module usbser_vreq_chk #(
  parameter int DIV_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       wr_data,
  input logic             commit_fire,
  input logic [7:0]       cur_code,
  input logic [7:0]       lcr_out,
  input logic [7:0]       mcr_out,
  input logic [DIV_W-1:0] div_out,
  input logic             div_load,
  input logic             cts_gate,
  input logic             req_stall,
  input logic             req_done,
  input logic             rd_valid,
  input logic             rpt_valid,
  input logic             rpt_first
);
  p_lcr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && cur_code == 8'd7) |=> (lcr_out == $past(wr_data)));

  p_mcr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && cur_code == 8'd10) |=> (mcr_out == ($past(wr_data) & 8'h1F)));

  p_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_fire && cur_code == 8'd5) |=> $stable(div_out));

  p_div_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && cur_code == 8'd5) |=> div_load);

  p_gate_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && cur_code == 8'd12) |=> (cts_gate == ($past(wr_data) != 8'd0)));

  p_nop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_fire && cur_code == 8'd11) |=> ($stable(lcr_out) && $stable(mcr_out) && $stable(cts_gate)));

  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |-> (!req_done && !rd_valid && $stable(lcr_out) && $stable(mcr_out)));

  p_rpt_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_first |=> (rpt_valid && !rpt_first));
endmodule

bind usbser_vreq_dec usbser_vreq_chk u_chk (.*);

// File: tb/usbser_vreq_dec_bench.sv
module usbser_vreq_dec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_valid = 1'b0;
  logic [7:0]  setup_type = 8'h00;
  logic [7:0]  setup_code = 8'h00;
  logic [15:0] setup_len = 16'd0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_take = 1'b0;
  logic [7:0]  msr_in = 8'h00;
  logic [7:0]  lsr_in = 8'h60;
  logic        rpt_start = 1'b0;
  logic        rd_valid, req_done, req_stall, rpt_valid, div_load, cts_gate, tx_allow;
  logic [7:0]  rd_data, rpt_data, lcr_out, mcr_out;
  logic [31:0] div_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbser_vreq_dec u_usbser_vreq_dec (
    .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_type(setup_type),
    .setup_code(setup_code), .setup_len(setup_len), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_take(rd_take), .rd_valid(rd_valid), .rd_data(rd_data), .req_done(req_done),
    .req_stall(req_stall), .msr_in(msr_in), .lsr_in(lsr_in), .rpt_start(rpt_start),
    .rpt_valid(rpt_valid), .rpt_data(rpt_data), .lcr_out(lcr_out), .mcr_out(mcr_out),
    .div_out(div_out), .div_load(div_load), .cts_gate(cts_gate), .tx_allow(tx_allow)
  );

  // ---------------- reference model ----------------
  int          m_st;        // 0 none, 1 write stage, 2 read stage
  int          m_len, m_cnt, m_rleft;
  logic [7:0]  m_code, m_lcr, m_mcr, m_rmsr, m_rlsr;
  logic [7:0]  m_buf [4];
  logic [31:0] m_div;
  logic        m_gate, m_done, m_stall, m_dl;

  function automatic int want_len(input logic [7:0] t, input logic [7:0] c);
    if (t == 8'h40) begin
      if (c == 8'd5) return 4;
      if (c == 8'd7 || c == 8'd10 || c == 8'd11 || c == 8'd12) return 1;
    end
    if (t == 8'hC0 && (c == 8'd2 || c == 8'd6)) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_len = 0; m_cnt = 0; m_rleft = 0; m_code = 0;
      m_lcr = 8'h03; m_mcr = 8'h00; m_div = 32'd12; m_gate = 0;
      m_done = 0; m_stall = 0; m_dl = 0; m_rmsr = 0; m_rlsr = 0;
    end else begin
      m_done = 0; m_stall = 0; m_dl = 0;
      if (setup_valid) begin
        int w;
        w = want_len(setup_type, setup_code);
        m_code = setup_code; m_cnt = 0; m_len = w;
        if (w == 0 || int'(setup_len) != w) begin m_st = 0; m_stall = 1; end
        else m_st = (setup_type == 8'hC0) ? 2 : 1;
      end else if (m_st == 1 && wr_valid) begin
        m_buf[m_cnt] = wr_data;
        if (m_cnt == m_len - 1) begin
          m_done = 1; m_st = 0;
          case (m_code)
            8'd7:  m_lcr = m_buf[0];
            8'd10: m_mcr = {3'b000, m_buf[0][4:0]};
            8'd12: m_gate = (m_buf[0] != 0);
            8'd5:  begin m_div = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]}; m_dl = 1; end
            default: ;
          endcase
        end else m_cnt++;
      end else if (m_st == 2 && rd_take) begin
        m_done = 1; m_st = 0;
      end
      if (m_rleft == 0) begin
        if (rpt_start) begin m_rleft = 2; m_rmsr = msr_in; m_rlsr = lsr_in; end
      end else m_rleft--;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 lcr_out", 32'(lcr_out), 32'(m_lcr));
    chk("R2 req_done", 32'(req_done), 32'(m_done));
    chk("R3 mcr_out", 32'(mcr_out), 32'(m_mcr));
    chk("R4 div_out", div_out, m_div);
    chk("R4 div_load", 32'(div_load), 32'(m_dl));
    chk("R5 cts_gate", 32'(cts_gate), 32'(m_gate));
    chk("R5 tx_allow", 32'(tx_allow), 32'(!m_gate || msr_in[4]));
    chk("R7 rd_valid", 32'(rd_valid), 32'(m_st == 2));
    if (m_st == 2) chk("R7 rd_data", 32'(rd_data), 32'((m_code == 8'd2) ? msr_in : m_lcr));
    chk("R8 req_stall", 32'(req_stall), 32'(m_stall));
    chk("R10 rpt_valid", 32'(rpt_valid), 32'(m_rleft != 0));
    if (m_rleft != 0) chk("R10 rpt_data", 32'(rpt_data), 32'((m_rleft == 2) ? m_rmsr : m_rlsr));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic setup(input logic [7:0] t, input logic [7:0] c, input int len);
    setup_valid = 1; setup_type = t; setup_code = c; setup_len = 16'(len);
    tick();
    setup_valid = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    wr_valid = 1; wr_data = b;
    tick();
    wr_valid = 0;
  endtask

  task automatic write1(input logic [7:0] c, input logic [7:0] b);
    setup(8'h40, c, 1);
    put_byte(b);
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s_lcr, s_mcr;
    logic [31:0] s_div;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 lcr", 32'(lcr_out), 32'h03);
    chk("R1 mcr", 32'(mcr_out), 32'h00);
    chk("R1 div", div_out, 32'd12);
    chk("R1 gate/stall/rd/rpt", 32'({cts_gate, req_stall, rd_valid, rpt_valid, req_done, div_load}), 32'h0);

    // R2 line control write
    write1(8'd7, 8'h1B);
    chk("R2 lcr value", 32'(lcr_out), 32'h1B);
    // R3 modem control write with masked top bits
    write1(8'd10, 8'hFF);
    chk("R3 mcr masked", 32'(mcr_out), 32'h1F);
    write1(8'd10, 8'hE2);
    chk("R3 mcr masked", 32'(mcr_out), 32'h02);

    // R4 divisor 115200/300 = 384, sent low byte first
    setup(8'h40, 8'd5, 4);
    put_byte(8'h80); put_byte(8'h01); put_byte(8'h00);
    chk("R4 div held mid-write", div_out, 32'd12);
    put_byte(8'h00);
    chk("R4 div committed", div_out, 32'd384);
    chk("R4 div_load pulse", 32'(div_load), 32'd1);
    tick();

    // R5 CTS gating
    msr_in = 8'h00;
    write1(8'd12, 8'h01);
    chk("R5 blocked without CTS", 32'(tx_allow), 32'd0);
    msr_in = 8'h10; tick();
    chk("R5 allowed with CTS", 32'(tx_allow), 32'd1);
    msr_in = 8'h00;
    write1(8'd12, 8'h00);
    chk("R5 allowed when ungated", 32'(tx_allow), 32'd1);

    // R6 no-op request
    s_lcr = lcr_out; s_mcr = mcr_out; s_div = div_out;
    setup(8'h40, 8'd11, 1);
    put_byte(8'h55);
    chk("R6 done pulse", 32'(req_done), 32'd1);
    tick();
    chk("R6 regs unchanged", {lcr_out, mcr_out, 15'd0, cts_gate}, {s_lcr, s_mcr, 16'd0});
    chk("R6 div unchanged", div_out, s_div);

    // R7 reads
    msr_in = 8'hA5;
    setup(8'hC0, 8'd2, 1);
    chk("R7 msr read", 32'(rd_data), 32'hA5);
    msr_in = 8'hB1; tick();
    chk("R7 msr live", 32'(rd_data), 32'hB1);
    rd_take = 1; tick(); rd_take = 0;
    chk("R7 done after take", 32'(req_done), 32'd1);
    setup(8'hC0, 8'd6, 1);
    chk("R7 lcr read", 32'(rd_data), 32'h1B);
    rd_take = 1; tick(); rd_take = 0; tick();

    // R8 rejected requests
    s_lcr = lcr_out; s_mcr = mcr_out;
    setup(8'h40, 8'd3, 1);
    chk("R8 unknown code stall", 32'(req_stall), 32'd1);
    put_byte(8'h77); tick();
    setup(8'h40, 8'd2, 1);
    chk("R8 wrong direction stall", 32'(req_stall), 32'd1);
    setup(8'h40, 8'd7, 2);
    chk("R8 wrong length stall", 32'(req_stall), 32'd1);
    put_byte(8'h99); put_byte(8'h98); tick();
    chk("R8 regs unchanged", {16'd0, lcr_out, mcr_out}, {16'd0, s_lcr, s_mcr});

    // R9 abort partial divisor; setup collides with a pending byte
    setup(8'h40, 8'd5, 4);
    put_byte(8'h11); put_byte(8'h22);
    wr_valid = 1; wr_data = 8'h33;
    setup(8'h40, 8'd7, 1);
    wr_valid = 0;
    put_byte(8'h07); tick();
    chk("R9 div unchanged", div_out, 32'd384);
    chk("R9 new request done", 32'(lcr_out), 32'h07);

    // R11 stray bytes
    put_byte(8'hFE); put_byte(8'h00); tick();
    chk("R11 lcr unchanged", 32'(lcr_out), 32'h07);
    chk("R11 div unchanged", div_out, 32'd384);

    // R10 report, colliding with a modem status read
    msr_in = 8'h5A; lsr_in = 8'h61;
    rpt_start = 1;
    setup(8'hC0, 8'd2, 1);
    rpt_start = 0;
    chk("R10 first byte msr", 32'(rpt_data), 32'h5A);
    msr_in = 8'h3C; lsr_in = 8'h20; rpt_start = 1;
    tick(); rpt_start = 0;
    chk("R10 second byte lsr", 32'(rpt_data), 32'h61);
    chk("R7 read follows live msr", 32'(rd_data), 32'h3C);
    rd_take = 1; tick(); rd_take = 0;
    chk("R10 busy start ignored", 32'(rpt_valid), 32'd0);
    rpt_start = 1; tick(); rpt_start = 0;
    chk("R10 new capture", 32'(rpt_data), 32'h3C);
    repeat (3) tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule